// File: doc/BRIEF.md
# PHY Interrupt Source Register

This block is the interrupt source register of a PHY management register file. Single-cycle pulses from the link logic set sticky status flags. Each pulse can mean link up, remote fault, link down, partner acknowledge, parallel-detect fault, page received, receive error or jabber. A per-source enable mask decides which flags drive the interrupt pin. The pin's active level comes from one bit of a separate control register.

Software reaches both registers through a simple register-access port, the same kind a serial management interface would drive. One read of the interrupt register returns the enable mask in the upper byte and the status flags in the lower byte. That read also clears the flags, so a service routine only needs that one access to collect the sources and acknowledge them. Enabled sources are usually limited to link up and link down.

Top module: `phy_irq_regfile`

## Requirements
- R1: After reset the enable mask, the status flags and the control register are all zero. The pin is therefore active low and idles high, and a read of address 0x1B returns 0x0000.
- R2: A pulse on event line n (n = 0..7) sets status bit n of register 0x1B at the next clock edge. This happens whether or not the source is enabled. Enable bit n+8 belongs to the same source. Line 0 is link up, 2 is link down and 7 is jabber.
- R3: A write to address 0x1B loads bits 15..8 of the write data into the enable mask. The status flags ignore the write data.
- R4: A read request to address 0x1B puts {enable mask, status flags} on the read-data port the cycle after the request. The value is the one held before the request edge.
- R5: A status flag stays set until a read of address 0x1B clears it.
- R6: An event that arrives in the same cycle as a clearing read is still set after the read. It is not part of the value that read returns.
- R7: The pin is active while at least one status flag has its enable bit set. A flag whose source is disabled never activates the pin.
- R8: Bit 9 of control register 0x1F selects the active pin level: 1 means active high, 0 means active low.
- R9: Control register 0x1F holds all 16 written bits and returns them on a read.
- R10: Reads of any other address return 0x0000. Writes to any other address change no register.
- R11: Writing 0x00 to the enable byte masks every source, even when status flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_req_i | input | 1 | Register access request, one cycle |
| mgmt_we_i | input | 1 | 1 = write, 0 = read |
| mgmt_addr_i | input | 5 | Register address |
| mgmt_wdata_i | input | 16 | Write data |
| mgmt_rdata_o | output | 16 | Read data, valid the cycle after a read request |
| link_evt_i | input | 8 | Event pulses, bit n sets status bit n |
| irq_pin_o | output | 1 | Interrupt pin at the programmed polarity |

## Verification
Assertions check on every cycle that flags are sticky until a clearing read, that each incoming event is captured even during a read, and that writes to the interrupt register leave the flags alone. They also check that the pin level matches the polarity bit whenever enabled flags are or are not pending, and that unmapped reads return zero. Only the bench scenarios show the exact read values. They also show the one-cycle read latency, the exclusion of a coincident event from the read that clears, polarity flips while a source is pending, and the state restored by a reset in mid-run.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
    localparam int SRC_N     = 8;
    localparam int REG_W     = 2 * SRC_N;
    localparam int ADDR_W    = 5;
    localparam logic [ADDR_W-1:0] INTC_ADDR = 5'h1B;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 5'h1F;
    localparam int POL_BIT   = 9;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_i,
    output logic [N-1:0] st_o
);
    typedef struct packed {
        logic [N-1:0] st;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) s_d.st = '0;
        s_d.st = s_d.st | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign st_o = s_q.st;

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((st_o & $past(st_o)) == $past(st_o))) else $error("sticky"); // R5
    AST_EVENT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((st_o & $past(evt_i)) == $past(evt_i))) else $error("capture"); // R6
    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && evt_i == '0) |=> (st_o == '0)) else $error("clear"); // R5
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int N = 8,
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_mask_i,
    input  logic         wr_ctrl_i,
    input  logic [W-1:0] wdata_i,
    output logic [N-1:0] en_o,
    output logic [W-1:0] ctrl_o
);
    localparam int EN_LSB = W - N;

    typedef struct packed {
        logic [N-1:0] en;
        logic [W-1:0] ctrl;
    } cfg_t;

    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr_mask_i) c_d.en   = wdata_i[W-1:EN_LSB];
        if (wr_ctrl_i) c_d.ctrl = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign en_o   = c_q.en;
    assign ctrl_o = c_q.ctrl;

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl_i |=> $stable(ctrl_o)) else $error("ctrl hold"); // R10
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask_i |=> $stable(en_o)) else $error("mask hold"); // R10
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
    parameter int N = 8
) (
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] st_i,
    input  logic         active_high_i,
    output logic         pin_o
);
    logic pending;

    always_comb begin
        pending = |(en_i & st_i);
        pin_o   = active_high_i ? pending : ~pending;
    end
endmodule

// File: rtl/phy_irq_regfile.sv
module phy_irq_regfile
    import phy_irq_pkg::*;
#(
    parameter int                 N_SRC  = SRC_N,
    parameter int                 W      = REG_W,
    parameter int                 AW     = ADDR_W,
    parameter logic [ADDR_W-1:0]  A_INTC = INTC_ADDR,
    parameter logic [ADDR_W-1:0]  A_CTRL = CTRL_ADDR,
    parameter int                 PBIT   = POL_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mgmt_req_i,
    input  logic          mgmt_we_i,
    input  logic [AW-1:0] mgmt_addr_i,
    input  logic [W-1:0]  mgmt_wdata_i,
    output logic [W-1:0]  mgmt_rdata_o,
    input  logic [N_SRC-1:0] link_evt_i,
    output logic          irq_pin_o
);
    localparam int PAD_W = W - 2 * N_SRC;

    typedef struct packed {
        logic [W-1:0] rdata;
    } port_t;

    port_t p_d, p_q;

    logic hit_intc, hit_ctrl, rd_intc, wr_intc, wr_ctrl, rd_ctrl;
    logic [N_SRC-1:0] en_w, st_w;
    logic [W-1:0]     ctrl_w;
    logic [W-1:0]     intc_view;

    always_comb begin
        hit_intc  = mgmt_req_i && (mgmt_addr_i == A_INTC);
        hit_ctrl  = mgmt_req_i && (mgmt_addr_i == A_CTRL);
        rd_intc   = hit_intc && !mgmt_we_i;
        wr_intc   = hit_intc &&  mgmt_we_i;
        rd_ctrl   = hit_ctrl && !mgmt_we_i;
        wr_ctrl   = hit_ctrl &&  mgmt_we_i;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign intc_view = {{PAD_W{1'b0}}, en_w, st_w};
        end else begin : g_nopad
            assign intc_view = {en_w, st_w};
        end
    endgenerate

    always_comb begin
        p_d = p_q;
        if (mgmt_req_i && !mgmt_we_i) begin
            if (rd_intc)      p_d.rdata = intc_view;
            else if (rd_ctrl) p_d.rdata = ctrl_w;
            else              p_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign mgmt_rdata_o = p_q.rdata;

    irq_status_bank #(.N(N_SRC)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (link_evt_i),
        .clr_i (rd_intc),
        .st_o  (st_w)
    );

    irq_cfg_regs #(.N(N_SRC), .W(W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mask_i (wr_intc),
        .wr_ctrl_i (wr_ctrl),
        .wdata_i   (mgmt_wdata_i),
        .en_o      (en_w),
        .ctrl_o    (ctrl_w)
    );

    irq_pin_drv #(.N(N_SRC)) u_pin (
        .en_i          (en_w),
        .st_i          (st_w),
        .active_high_i (ctrl_w[PBIT]),
        .pin_o         (irq_pin_o)
    );

    AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_w & st_w) == '0) |-> (irq_pin_o == !ctrl_w[PBIT])) else $error("pin idle"); // R8
    AST_PIN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_w & st_w) != '0) |-> (irq_pin_o == ctrl_w[PBIT])) else $error("pin active"); // R7
    AST_WRITE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_intc && link_evt_i == '0) |=> $stable(st_w)) else $error("write flags"); // R3
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_req_i && !mgmt_we_i && !hit_intc && !hit_ctrl) |=> (mgmt_rdata_o == '0)) else $error("unmapped"); // R10
endmodule

// File: tb/phy_irq_regfile_bench.sv
module phy_irq_regfile_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 19;

    // op(2) addr(5) wdata(16) evt(8) chk(1) exp_rdata(16) exp_pin(1) tag(4)
    localparam logic [52:0] VEC [NV] = '{
        {2'd1, 5'h1B, 16'h0500, 8'h00, 1'b0, 16'h0000, 1'b1, 4'd11}, // typical link up/down mask
        {2'd0, 5'h00, 16'h0000, 8'h01, 1'b0, 16'h0000, 1'b0, 4'd7},  // link up, active low
        {2'd2, 5'h1B, 16'h0000, 8'h00, 1'b1, 16'h0501, 1'b1, 4'd4},
        {2'd0, 5'h00, 16'h0000, 8'h80, 1'b0, 16'h0000, 1'b1, 4'd7},  // jabber masked
        {2'd2, 5'h1B, 16'h0000, 8'h00, 1'b1, 16'h0580, 1'b1, 4'd2},
        {2'd2, 5'h1B, 16'h0000, 8'h00, 1'b1, 16'h0500, 1'b1, 4'd5},
        {2'd1, 5'h1F, 16'h0200, 8'h00, 1'b0, 16'h0000, 1'b0, 4'd8},  // active high, idle
        {2'd0, 5'h00, 16'h0000, 8'h04, 1'b0, 16'h0000, 1'b1, 4'd8},  // link down
        {2'd2, 5'h1F, 16'h0000, 8'h00, 1'b1, 16'h0200, 1'b1, 4'd9},
        {2'd1, 5'h1B, 16'hFFFF, 8'h00, 1'b0, 16'h0000, 1'b1, 4'd3},
        {2'd2, 5'h1B, 16'h0000, 8'h02, 1'b1, 16'hFF04, 1'b1, 4'd6},  // coincident event
        {2'd2, 5'h1B, 16'h0000, 8'h00, 1'b1, 16'hFF02, 1'b0, 4'd6},
        {2'd1, 5'h1B, 16'h0000, 8'h40, 1'b0, 16'h0000, 1'b0, 4'd11}, // mask all
        {2'd2, 5'h1B, 16'h0000, 8'h00, 1'b1, 16'h0040, 1'b0, 4'd11},
        {2'd1, 5'h05, 16'hFFFF, 8'h00, 1'b0, 16'h0000, 1'b0, 4'd10},
        {2'd2, 5'h05, 16'h0000, 8'h00, 1'b1, 16'h0000, 1'b0, 4'd10},
        {2'd2, 5'h1F, 16'h0000, 8'h00, 1'b1, 16'h0200, 1'b0, 4'd10},
        {2'd1, 5'h1F, 16'h0000, 8'h00, 1'b0, 16'h0000, 1'b1, 4'd8},
        {2'd2, 5'h1B, 16'h0000, 8'h00, 1'b1, 16'h0000, 1'b1, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [7:0]  evt = '0;
    logic        pin;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_irq_regfile u_phy_irq_regfile (
        .clk          (clk),
        .rst_n        (rst_n),
        .mgmt_req_i   (req),
        .mgmt_we_i    (we),
        .mgmt_addr_i  (addr),
        .mgmt_wdata_i (wdata),
        .mgmt_rdata_o (rdata),
        .link_evt_i   (evt),
        .irq_pin_o    (pin)
    );

    function automatic string req_name(int t);
        case (t)
            1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
            5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
            9: return "R9";  10: return "R10"; 11: return "R11";
            default: return "R?";
        endcase
    endfunction

    task automatic check(string r, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic step(logic [1:0] op, logic [4:0] a, logic [15:0] d, logic [7:0] e);
        @(negedge clk);
        req   = (op != 2'd0);
        we    = (op == 2'd1);
        addr  = a;
        wdata = d;
        evt   = e;
        @(posedge clk);
        #1;
        req = 1'b0; we = 1'b0; evt = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", {15'd0, pin}, 16'd1);
        @(negedge clk) rst_n = 1'b1;
        step(2'd2, 5'h1B, 16'h0, 8'h0);
        check("R1", rdata, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            logic [52:0] v;
            v = VEC[i];
            step(v[52:51], v[50:46], v[45:30], v[29:22]);
            check(req_name(int'(v[3:0])), {15'd0, pin}, {15'd0, v[4]});
            if (v[21]) check(req_name(int'(v[3:0])), rdata, v[20:5]);
        end

        // R9: full control value kept
        step(2'd1, 5'h1F, 16'hA5C3, 8'h00);
        step(2'd2, 5'h1F, 16'h0000, 8'h00);
        check("R9", rdata, 16'hA5C3);

        // R8: polarity flip while a source is pending
        step(2'd1, 5'h1B, 16'h0100, 8'h01);
        check("R8", {15'd0, pin}, 16'd0);  // bit9 of A5C3 is 0: active low
        step(2'd1, 5'h1F, 16'h0200, 8'h00);
        check("R8", {15'd0, pin}, 16'd1);

        // R1: reset in mid-run restores idle state
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1", {15'd0, pin}, 16'd1);
        @(negedge clk) rst_n = 1'b1;
        step(2'd2, 5'h1B, 16'h0, 8'h0);
        check("R1", rdata, 16'h0000);
        step(2'd2, 5'h1F, 16'h0, 8'h0);
        check("R1", rdata, 16'h0000);

        // R2: every event line maps to its own status bit
        for (int b = 0; b < 8; b++) begin
            step(2'd0, 5'h00, 16'h0, 8'(1 << b));
            step(2'd2, 5'h1B, 16'h0, 8'h00);
            check("R2", rdata, 16'(1 << b));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule